// File: doc/BRIEF.md
# Card Detect Interrupt Controller

This block collects the interrupt sources of a two-slot card reader into one pending word and gates them onto a single interrupt line through a separate enable word. Each slot has a card-present input. Any change on that input, insertion or removal, latches a per-slot change bit. Three event pulses also latch their own bits: transfer completed, transfer failed and link lost. Software clears pending bits by writing 1 to them.

The status word also carries the live card-present level of every slot in read-only positions. A handler can therefore learn what changed and what the slot now holds from a single read. A small result output reports the outcome of the last transfer from the pending bits. A failure or a lost link outranks a success when both are pending.

The register port is plain: a write strobe with a one-bit word select and write data, and a one-bit read select driving combinational read data. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `card_irq_ctrl`

## Requirements
- R1: After reset all pending bits are 0, `irq` is 0 and `xfer_result` is 2'b00. The enable word reads 0x0000_0303: transfer-OK (bit 0), transfer-fail (bit 1) and slot 0 change (bit 8), plus slot 1 change (bit 9) only when NUM_SLOTS is greater than 1.
- R2: A one-cycle pulse on `xfer_ok_i`, `xfer_fail_i` or `link_down_i` sets status bit 0, 1 or 2 respectively. The bit is visible after the clock edge that samples the pulse.
- R3: A rising or a falling edge on `card_present_i[s]` sets status change bit 8+s after the clock edge that first samples the new level.
- R4: Status bits 16+s always show the live `card_present_i[s]`. Writing 1 to them has no effect on anything.
- R5: Writing the status word (`wr_sel_i`=0) clears every pending bit written with 1 and leaves every pending bit written with 0 unchanged.
- R6: If an event arrives in the same cycle as a write-1 clear of its bit, the bit stays set.
- R7: `irq` is 1 exactly when some pending bit is set whose enable bit is also set.
- R8: Writing the enable word (`wr_sel_i`=1) stores the implemented enable bits: 0, 1, 2, and 8+s for each slot. All other enable bits read 0. Writing the enable word leaves the pending bits untouched.
- R9: `xfer_result` is 2'b10 (fail) while bit 1 or bit 2 is pending. Otherwise it is 2'b01 (ok) while bit 0 is pending. Otherwise it is 2'b00.
- R10: A card already present when reset is released does not set its change bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_present_i | input | NUM_SLOTS | Live card-present level per slot, synchronous to clk |
| xfer_ok_i | input | 1 | Transfer-completed event pulse |
| xfer_fail_i | input | 1 | Transfer-failed event pulse |
| link_down_i | input | 1 | Link-lost event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (write-1-to-clear), 1 enable |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read source: 0 status, 1 enable |
| rd_data_o | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |
| xfer_result | output | 2 | Transfer outcome: 00 none, 01 ok, 10 fail |

## Verification
The assertions take the card-present inputs and the event pulses to be already synchronous to `clk`. They also take every fall of `irq` to be caused by a register write, so no other source may clear state. The bench drives every input half a cycle away from the active edge. It holds each pulse for exactly one sampling edge, and it only changes card-present levels after reset has been released for at least one edge, except for the deliberate level held through reset.

// File: rtl/cdic_pkg.sv
package cdic_pkg;
  localparam int REG_W     = 32;
  localparam int OK_BIT    = 0;
  localparam int FAIL_BIT  = 1;
  localparam int LINK_BIT  = 2;
  localparam int CHG_BASE  = 8;
  localparam int LIVE_BASE = 16;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_OK   = 2'b01,
    RES_FAIL = 2'b10
  } xfer_res_e;

  function automatic logic [REG_W-1:0] chg_mask(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[CHG_BASE+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] impl_en_mask(input int n);
    logic [REG_W-1:0] m;
    m = chg_mask(n);
    m[OK_BIT]   = 1'b1;
    m[FAIL_BIT] = 1'b1;
    m[LINK_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] reset_en(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    m[OK_BIT]   = 1'b1;
    m[FAIL_BIT] = 1'b1;
    m[CHG_BASE] = 1'b1;
    if (n > 1) m[CHG_BASE+1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cdic_edge_det.sv
module cdic_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic change_o
);
  logic last_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      last_q  <= level_i;
      armed_q <= 1'b1;
    end
  end

  // first sample after reset only primes the history (R10)
  assign change_o = armed_q & (level_i ^ last_q);
endmodule

// File: rtl/cdic_w1c_bank.sv
module cdic_w1c_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)        q[b] <= 1'b0;
        else if (set_i[b]) q[b] <= 1'b1;
        else if (clr_i[b]) q[b] <= 1'b0;
      end

      p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[b] |=> q[b]);
      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[b] && !set_i[b]) |=> !q[b]);
    end
  endgenerate

  assign q_o = q;
endmodule

// File: rtl/cdic_enable_reg.sv
module cdic_enable_reg #(
  parameter int               W      = 32,
  parameter logic [W-1:0]     IMPL   = '0,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    en_q <= RST_VAL & IMPL;
    else if (we_i) en_q <= wdata_i & IMPL;
  end

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(en_q));

  assign en_o = en_q;
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import cdic_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] card_present_i,
  input  logic                 xfer_ok_i,
  input  logic                 xfer_fail_i,
  input  logic                 link_down_i,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [31:0]          wr_data_i,
  input  logic                 rd_sel_i,
  output logic [31:0]          rd_data_o,
  output logic                 irq,
  output logic [1:0]           xfer_result
);
  localparam logic [REG_W-1:0] IMPL_EN = impl_en_mask(NUM_SLOTS);
  localparam logic [REG_W-1:0] RST_EN  = reset_en(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] slot_chg;
  logic [REG_W-1:0]     evt_vec;
  logic [REG_W-1:0]     clr_vec;
  logic [REG_W-1:0]     pend;
  logic [REG_W-1:0]     en;
  logic [REG_W-1:0]     live_vec;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      cdic_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (card_present_i[s]),
        .change_o (slot_chg[s])
      );

      p_chg_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_chg[s] |=> pend[CHG_BASE+s]);
    end
  endgenerate

  always_comb begin
    evt_vec = '0;
    evt_vec[OK_BIT]   = xfer_ok_i;
    evt_vec[FAIL_BIT] = xfer_fail_i;
    evt_vec[LINK_BIT] = link_down_i;
    for (int s = 0; s < NUM_SLOTS; s++) evt_vec[CHG_BASE+s] = slot_chg[s];
  end

  // live level positions are excluded from clearing (R4)
  assign clr_vec = (wr_en_i && !wr_sel_i) ? (wr_data_i & IMPL_EN) : '0;

  cdic_w1c_bank #(.W(REG_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_vec),
    .clr_i (clr_vec),
    .q_o   (pend)
  );

  cdic_enable_reg #(.W(REG_W), .IMPL(IMPL_EN), .RST_VAL(RST_EN)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en_i && wr_sel_i),
    .wdata_i (wr_data_i),
    .en_o    (en)
  );

  always_comb begin
    live_vec = '0;
    for (int s = 0; s < NUM_SLOTS; s++) live_vec[LIVE_BASE+s] = card_present_i[s];
  end

  assign rd_data_o = rd_sel_i ? en : (pend | live_vec);
  assign irq       = |(pend & en);

  always_comb begin
    if (pend[FAIL_BIT] || pend[LINK_BIT]) xfer_result = RES_FAIL;
    else if (pend[OK_BIT])                xfer_result = RES_OK;
    else                                  xfer_result = RES_NONE;
  end

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en_i));
endmodule

// File: tb/card_irq_ctrl_test.sv
`timescale 1ns/1ps
module card_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pres;
  logic        ok_p, fail_p, link_p;
  logic        we, wsel, rsel;
  logic [31:0] wd;
  logic [31:0] rd;
  logic        irq;
  logic [1:0]  res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  card_irq_ctrl #(.NUM_SLOTS(2)) uut (
    .clk(clk), .rst_n(rst_n), .card_present_i(pres),
    .xfer_ok_i(ok_p), .xfer_fail_i(fail_p), .link_down_i(link_p),
    .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wd),
    .rd_sel_i(rsel), .rd_data_o(rd), .irq(irq), .xfer_result(res)
  );

  typedef struct packed {
    logic [1:0]  pres;
    logic        ok, fail, link, we;
    logic [31:0] wd;
    logic [31:0] st;
    logic        irq;
    logic [1:0]  res;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0,1'b0,1'b0,1'b0, 32'h0,          32'h0001_0000, 1'b0, 2'b00}, // R10
    '{2'b01, 1'b1,1'b0,1'b0,1'b0, 32'h0,          32'h0001_0001, 1'b1, 2'b01}, // R2
    '{2'b01, 1'b0,1'b1,1'b0,1'b0, 32'h0,          32'h0001_0003, 1'b1, 2'b10}, // R9
    '{2'b01, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0002,  32'h0001_0001, 1'b1, 2'b01}, // R5
    '{2'b01, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0001,  32'h0001_0000, 1'b0, 2'b00}, // R5
    '{2'b11, 1'b0,1'b0,1'b0,1'b0, 32'h0,          32'h0003_0200, 1'b1, 2'b00}, // R3 rise
    '{2'b10, 1'b0,1'b0,1'b0,1'b0, 32'h0,          32'h0002_0300, 1'b1, 2'b00}, // R3 fall
    '{2'b10, 1'b0,1'b0,1'b0,1'b1, 32'h0003_0000,  32'h0002_0300, 1'b1, 2'b00}, // R4
    '{2'b10, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0300,  32'h0002_0000, 1'b0, 2'b00}, // R5
    '{2'b10, 1'b0,1'b0,1'b1,1'b0, 32'h0,          32'h0002_0004, 1'b0, 2'b10}, // R7 R9
    '{2'b10, 1'b1,1'b0,1'b0,1'b0, 32'h0,          32'h0002_0005, 1'b1, 2'b10}, // R9
    '{2'b10, 1'b0,1'b0,1'b1,1'b1, 32'h0000_0004,  32'h0002_0005, 1'b1, 2'b10}, // R6
    '{2'b10, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0005,  32'h0002_0000, 1'b0, 2'b00}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ok_p = 0; fail_p = 0; link_p = 0; we = 0; wsel = 0; wd = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 0; pres = 2'b01; rsel = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step();

    // R1: reset state
    rsel = 1; #0.1;
    check("R1 enable", rd, 32'h0000_0303);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 result", {30'b0, res}, 32'h0);
    rsel = 0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pres = VECS[i].pres; ok_p = VECS[i].ok; fail_p = VECS[i].fail;
      link_p = VECS[i].link; we = VECS[i].we; wsel = 0; wd = VECS[i].wd;
      step();
      check($sformatf("R3/R4/R5 status v%0d", i), rd, VECS[i].st);
      check($sformatf("R7 irq v%0d", i), {31'b0, irq}, {31'b0, VECS[i].irq});
      check($sformatf("R9 result v%0d", i), {30'b0, res}, {30'b0, VECS[i].res});
    end
    @(negedge clk); idle_inputs();

    // R8: enable write keeps only implemented bits, pending untouched
    link_p = 1; step();
    @(negedge clk); idle_inputs();
    check("R7 link masked", {31'b0, irq}, 32'h0);
    we = 1; wsel = 1; wd = 32'hFFFF_FFFF; step();
    @(negedge clk); idle_inputs();
    rsel = 1; #0.1;
    check("R8 enable mask", rd, 32'h0000_0307);
    check("R7 link enabled", {31'b0, irq}, 32'h1);
    rsel = 0; #0.1;
    check("R8 pending kept", rd, 32'h0002_0004);
    we = 1; wsel = 1; wd = 32'h0; step();
    @(negedge clk); idle_inputs();
    check("R7 all disabled", {31'b0, irq}, 32'h0);
    check("R8 pending kept 2", rd, 32'h0002_0004);
    check("R9 link fail", {30'b0, res}, 32'h2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule